// File: doc/BRIEF.md
# NAND Page Program Order Checker

This block sits beside a flash command path and judges every program command before it reaches the array. For each tracked block it remembers the cell mode in force, the next page that may be written and how many program passes the most recently written page has received. A program command is accepted only if it continues the ascending page sequence from page 0, or if it is an allowed partial re-program of the newest page. An erase command wipes the block's history and latches the cell mode for the block's next life.

Each command gets a verdict one clock later: a single-cycle valid pulse, an accept flag and a 2-bit reason code. Flash timing, data movement and error correction belong to other blocks. The number of tracked blocks is a parameter and is kept small.

Top module: `nand_pgm_order_chk`

## Requirements
- R1: After reset or erase, the first accepted program of a block is page 0, and each later new page must equal the previous new page plus one; a program to any other page (not the most recent one) returns code 01 (order violation) and changes no state.
- R2: Valid page indices are 0..63 for a block in single-level mode and 0..127 for a block in multi-level mode; a higher index returns code 11 (out of range), and this check wins over every other check.
- R3: In multi-level mode a program that repeats the most recently programmed page returns code 10 (program count exceeded).
- R4: In single-level mode the most recently programmed page may be programmed up to 4 times in total; the fifth and later programs of that page return code 10.
- R5: In single-level mode, going back to a page below the most recent one, or skipping past the next page, returns code 01.
- R6: An erase (cmd_op = 1) always returns code 00, resets the block's next-page pointer to 0 and clears its program count.
- R7: cmd_mlc (1 = multi-level, 0 = single-level) is sampled only by an erase and governs that block until its next erase; its value during program commands has no effect.
- R8: rsp_valid is high for exactly the one cycle after each cycle with cmd_valid high and low otherwise; rsp_ok is 1 exactly when the reported code is 00.
- R9: After reset every block is empty and in single-level mode, and rsp_valid and rsp_ok are low.
- R10: Blocks keep independent state; a command to one block does not change the verdicts for another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 1 | 0 = program, 1 = erase |
| cmd_blk | input | BLK_AW (2) | Tracked block index |
| cmd_page | input | PAGE_AW (7) | Page index within the block |
| cmd_mlc | input | 1 | Cell mode for an erase: 1 multi-level, 0 single-level |
| rsp_valid | output | 1 | Verdict strobe, one cycle after the command |
| rsp_ok | output | 1 | Command accepted |
| rsp_err | output | 2 | 00 accepted, 01 order, 10 count exceeded, 11 out of range |

## Verification
The hardest states to reach are the ends of a block: the page after the last valid one, and a repeat of the last page, which exist only after 64 or 128 ordered programs without an erase in between. The bench gets there by erasing a block in each mode and then walking every page in ascending order, checking each step, before probing one page past the end and re-programming the final page. The fifth partial program of a single-level page is reached the same way, by repeating one page four times after an erase.

// File: rtl/nand_chk_pkg.sv
package nand_chk_pkg;
  typedef enum logic [1:0] {
    ERR_NONE  = 2'b00,
    ERR_ORDER = 2'b01,
    ERR_COUNT = 2'b10,
    ERR_RANGE = 2'b11
  } chk_err_t;

  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } chk_op_t;
endpackage

// File: rtl/nand_blk_state.sv
module nand_blk_state #(
  parameter int NXT_W = 8,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             erase_en,
  input  logic             erase_mlc,
  input  logic             upd_en,
  input  logic [NXT_W-1:0] nxt_in,
  input  logic [CNT_W-1:0] cnt_in,
  output logic             mode_q,
  output logic [NXT_W-1:0] nxt_q,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      nxt_q  <= '0;
      cnt_q  <= '0;
    end else if (erase_en) begin
      mode_q <= erase_mlc;
      nxt_q  <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      nxt_q  <= nxt_in;
      cnt_q  <= cnt_in;
    end
  end
endmodule

// File: rtl/nand_pgm_judge.sv
module nand_pgm_judge
  import nand_chk_pkg::*;
#(
  parameter int PAGE_AW      = 7,
  parameter int NXT_W        = 8,
  parameter int CNT_W        = 3,
  parameter int SLC_PAGES    = 64,
  parameter int MLC_PAGES    = 128,
  parameter int SLC_MAX_PROG = 4
) (
  input  logic               blk_mlc,
  input  logic [NXT_W-1:0]   blk_nxt,
  input  logic [CNT_W-1:0]   blk_cnt,
  input  logic [PAGE_AW-1:0] page,
  output chk_err_t           verdict,
  output logic [NXT_W-1:0]   nxt_upd,
  output logic [CNT_W-1:0]   cnt_upd
);
  localparam logic [NXT_W-1:0] SLC_LAST = NXT_W'(SLC_PAGES - 1);
  localparam logic [NXT_W-1:0] MLC_LAST = NXT_W'(MLC_PAGES - 1);
  localparam logic [CNT_W-1:0] SLC_CAP  = CNT_W'(SLC_MAX_PROG);

  function automatic logic [NXT_W-1:0] last_page_of(input logic mlc);
    return mlc ? MLC_LAST : SLC_LAST;
  endfunction

  function automatic logic hits_newest(input logic [NXT_W-1:0] nxt,
                                       input logic [NXT_W-1:0] pg);
    return (nxt != '0) && (pg == nxt - 1'b1);
  endfunction

  logic [NXT_W-1:0] pg_ext;
  assign pg_ext = NXT_W'(page);

  always_comb begin
    verdict = ERR_ORDER;
    nxt_upd = blk_nxt;
    cnt_upd = blk_cnt;
    if (pg_ext > last_page_of(blk_mlc)) begin
      verdict = ERR_RANGE;
    end else if (pg_ext == blk_nxt) begin
      verdict = ERR_NONE;
      nxt_upd = blk_nxt + 1'b1;
      cnt_upd = CNT_W'(1);
    end else if (hits_newest(blk_nxt, pg_ext)) begin
      if (blk_mlc || blk_cnt >= SLC_CAP) begin
        verdict = ERR_COUNT;
      end else begin
        verdict = ERR_NONE;
        cnt_upd = blk_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nand_pgm_order_chk.sv
module nand_pgm_order_chk
  import nand_chk_pkg::*;
#(
  parameter int NUM_BLOCKS   = 4,
  parameter int SLC_PAGES    = 64,
  parameter int MLC_PAGES    = 128,
  parameter int SLC_MAX_PROG = 4,
  localparam int BLK_AW      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int PAGE_AW     = $clog2(MLC_PAGES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic               cmd_op,
  input  logic [BLK_AW-1:0]  cmd_blk,
  input  logic [PAGE_AW-1:0] cmd_page,
  input  logic               cmd_mlc,
  output logic               rsp_valid,
  output logic               rsp_ok,
  output logic [1:0]         rsp_err
);
  localparam int NXT_W = PAGE_AW + 1;
  localparam int CNT_W = $clog2(SLC_MAX_PROG + 1);

  logic             mode_a [NUM_BLOCKS];
  logic [NXT_W-1:0] nxt_a  [NUM_BLOCKS];
  logic [CNT_W-1:0] cnt_a  [NUM_BLOCKS];

  // Named events for the checker
  logic             ev_prog, ev_erase, ev_accept;
  logic             cur_mode;
  logic [NXT_W-1:0] cur_nxt, nxt_upd;
  logic [CNT_W-1:0] cur_cnt, cnt_upd;
  chk_err_t         verdict;

  assign ev_prog   = cmd_valid && (chk_op_t'(cmd_op) == OP_PROGRAM);
  assign ev_erase  = cmd_valid && (chk_op_t'(cmd_op) == OP_ERASE);
  assign cur_mode  = mode_a[cmd_blk];
  assign cur_nxt   = nxt_a[cmd_blk];
  assign cur_cnt   = cnt_a[cmd_blk];
  assign ev_accept = ev_prog && (verdict == ERR_NONE);

  nand_pgm_judge #(
    .PAGE_AW(PAGE_AW), .NXT_W(NXT_W), .CNT_W(CNT_W),
    .SLC_PAGES(SLC_PAGES), .MLC_PAGES(MLC_PAGES), .SLC_MAX_PROG(SLC_MAX_PROG)
  ) u_judge (
    .blk_mlc(cur_mode), .blk_nxt(cur_nxt), .blk_cnt(cur_cnt), .page(cmd_page),
    .verdict(verdict), .nxt_upd(nxt_upd), .cnt_upd(cnt_upd)
  );

  for (genvar gi = 0; gi < NUM_BLOCKS; gi++) begin : g_blk
    logic hit;
    assign hit = (cmd_blk == BLK_AW'(gi));
    nand_blk_state #(.NXT_W(NXT_W), .CNT_W(CNT_W)) u_state (
      .clk(clk), .rst_n(rst_n),
      .erase_en(ev_erase && hit), .erase_mlc(cmd_mlc),
      .upd_en(ev_accept && hit), .nxt_in(nxt_upd), .cnt_in(cnt_upd),
      .mode_q(mode_a[gi]), .nxt_q(nxt_a[gi]), .cnt_q(cnt_a[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_err   <= ERR_NONE;
    end else begin
      rsp_valid <= cmd_valid;
      if (cmd_valid) begin
        rsp_err <= ev_erase ? ERR_NONE : verdict;
        rsp_ok  <= ev_erase || (verdict == ERR_NONE);
      end else begin
        rsp_ok  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nand_pgm_order_sva.sv
module nand_pgm_order_sva #(
  parameter int PAGE_AW      = 7,
  parameter int NXT_W        = 8,
  parameter int CNT_W        = 3,
  parameter int SLC_PAGES    = 64,
  parameter int MLC_PAGES    = 128,
  parameter int SLC_MAX_PROG = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               ev_prog,
  input logic               ev_erase,
  input logic [PAGE_AW-1:0] cmd_page,
  input logic               cur_mode,
  input logic [NXT_W-1:0]   cur_nxt,
  input logic [CNT_W-1:0]   cur_cnt,
  input logic               rsp_valid,
  input logic               rsp_ok,
  input logic [1:0]         rsp_err
);
  logic [NXT_W-1:0] lim;
  logic             over, repeat_pg;
  assign lim       = cur_mode ? NXT_W'(MLC_PAGES - 1) : NXT_W'(SLC_PAGES - 1);
  assign over      = NXT_W'(cmd_page) > lim;
  assign repeat_pg = (cur_nxt != '0) && (NXT_W'(cmd_page) + 1'b1 == cur_nxt);

  assert_resp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid);
  assert_ok_matches_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_ok == (rsp_err == 2'b00)));
  assert_erase_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_erase |=> (rsp_err == 2'b00));
  assert_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_prog && over) |=> (rsp_err == 2'b11));
  assert_mlc_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_prog && cur_mode && !over && repeat_pg) |=> (rsp_err == 2'b10));
  assert_cnt_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cur_cnt <= CNT_W'(SLC_MAX_PROG));
endmodule

bind nand_pgm_order_chk nand_pgm_order_sva #(
  .PAGE_AW(PAGE_AW), .NXT_W(NXT_W), .CNT_W(CNT_W),
  .SLC_PAGES(SLC_PAGES), .MLC_PAGES(MLC_PAGES), .SLC_MAX_PROG(SLC_MAX_PROG)
) u_sva (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .ev_prog(ev_prog),
  .ev_erase(ev_erase), .cmd_page(cmd_page), .cur_mode(cur_mode),
  .cur_nxt(cur_nxt), .cur_cnt(cur_cnt), .rsp_valid(rsp_valid),
  .rsp_ok(rsp_ok), .rsp_err(rsp_err)
);

// File: tb/nand_pgm_order_chk_test.sv
module nand_pgm_order_chk_test;
  localparam logic PRG = 1'b0;
  localparam logic ERS = 1'b1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_op = 1'b0;
  logic [1:0] cmd_blk = '0;
  logic [6:0] cmd_page = '0;
  logic       cmd_mlc = 1'b0;
  logic       rsp_valid, rsp_ok;
  logic [1:0] rsp_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nand_pgm_order_chk uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_blk(cmd_blk), .cmd_page(cmd_page), .cmd_mlc(cmd_mlc),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_err(rsp_err)
  );

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issue one command and check its verdict in the following cycle
  task automatic cmd(input logic op, input int blk, input int pg, input logic mlc,
                     input logic [1:0] exp, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_blk = 2'(blk); cmd_page = 7'(pg); cmd_mlc = mlc;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(rsp_valid && rsp_err == exp && rsp_ok == (exp == 2'b00), req,
          {rsp_valid, rsp_ok, rsp_err}, {1'b1, exp == 2'b00, exp});
  endtask

  task automatic t_reset();
    check(!rsp_valid && !rsp_ok, "R9 idle after reset", {rsp_valid, rsp_ok}, 0);
    cmd(PRG, 1, 64, 1'b1, 2'b11, "R9 reset block is single-level");
    cmd(PRG, 1, 0, 1'b0, 2'b00, "R9 reset block empty, page 0 accepted");
  endtask

  task automatic t_order();
    cmd(PRG, 0, 1, 1'b0, 2'b01, "R1 first program must be page 0");
    cmd(PRG, 0, 0, 1'b0, 2'b00, "R1 page 0 accepted");
    cmd(PRG, 0, 2, 1'b0, 2'b01, "R5 skip ahead rejected");
    cmd(PRG, 0, 1, 1'b0, 2'b00, "R1 next page accepted");
    cmd(PRG, 0, 0, 1'b0, 2'b01, "R5 going back rejected");
    cmd(PRG, 0, 1, 1'b0, 2'b00, "R4 partial on newest page");
  endtask

  task automatic t_slc_partial();
    cmd(ERS, 2, 0, 1'b0, 2'b00, "R6 erase single-level");
    for (int i = 0; i < 4; i++) cmd(PRG, 2, 0, 1'b0, 2'b00, "R4 partial program within limit");
    cmd(PRG, 2, 0, 1'b0, 2'b10, "R4 fifth program rejected");
    cmd(PRG, 2, 1, 1'b0, 2'b00, "R4 next page starts fresh count");
    cmd(PRG, 2, 1, 1'b0, 2'b00, "R4 second pass on new page");
  endtask

  task automatic t_erase();
    cmd(ERS, 2, 0, 1'b1, 2'b00, "R6 erase returns 00");
    cmd(ERS, 2, 5, 1'b0, 2'b00, "R6 erase back to single-level");
    cmd(PRG, 2, 1, 1'b0, 2'b01, "R6 pointer reset to 0");
    for (int i = 0; i < 4; i++) cmd(PRG, 2, 0, 1'b0, 2'b00, "R6 counts cleared");
    cmd(PRG, 2, 0, 1'b0, 2'b10, "R6 limit applies after erase");
  endtask

  task automatic t_mlc();
    cmd(ERS, 3, 0, 1'b1, 2'b00, "R7 erase multi-level");
    cmd(PRG, 3, 0, 1'b0, 2'b00, "R3 page 0 once");
    cmd(PRG, 3, 0, 1'b0, 2'b10, "R3 R7 repeat rejected though cmd_mlc=0");
    cmd(PRG, 3, 1, 1'b0, 2'b00, "R3 next page");
    cmd(PRG, 3, 100, 1'b0, 2'b01, "R2 page 100 in range for multi-level, out of order");
  endtask

  task automatic t_mode_sample();
    cmd(ERS, 0, 0, 1'b0, 2'b00, "R7 erase single-level");
    cmd(PRG, 0, 0, 1'b1, 2'b00, "R7 program with cmd_mlc=1");
    cmd(PRG, 0, 0, 1'b1, 2'b00, "R7 partial still allowed");
    cmd(PRG, 0, 100, 1'b1, 2'b11, "R7 single-level range kept");
  endtask

  task automatic t_indep();
    cmd(PRG, 3, 2, 1'b0, 2'b00, "R10 block 3 continues at page 2");
    cmd(PRG, 0, 1, 1'b0, 2'b00, "R10 block 0 continues at page 1");
    cmd(PRG, 3, 1, 1'b0, 2'b01, "R10 block 3 history intact");
  endtask

  task automatic t_fill_slc();
    cmd(ERS, 1, 0, 1'b0, 2'b00, "R2 erase single-level");
    for (int p = 0; p < 64; p++) cmd(PRG, 1, p, 1'b0, 2'b00, "R1 ascending fill");
    cmd(PRG, 1, 64, 1'b0, 2'b11, "R2 page 64 out of range");
    cmd(PRG, 1, 127, 1'b0, 2'b11, "R2 page 127 out of range");
    cmd(PRG, 1, 63, 1'b0, 2'b00, "R4 partial on last page");
  endtask

  task automatic t_fill_mlc();
    cmd(ERS, 1, 0, 1'b1, 2'b00, "R2 erase multi-level");
    for (int p = 0; p < 128; p++) cmd(PRG, 1, p, 1'b0, 2'b00, "R2 multi-level fill");
    cmd(PRG, 1, 127, 1'b0, 2'b10, "R3 last page repeat");
    cmd(PRG, 1, 5, 1'b0, 2'b01, "R1 earlier page after fill");
  endtask

  task automatic t_timing();
    @(negedge clk);
    check(!rsp_valid && !rsp_ok, "R8 no response when idle", rsp_valid, 0);
    cmd(PRG, 2, 1, 1'b0, 2'b00, "R8 response one cycle later");
    @(negedge clk);
    check(!rsp_valid && !rsp_ok, "R8 single-cycle pulse", rsp_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_order();
    t_slc_partial();
    t_erase();
    t_mlc();
    t_mode_sample();
    t_indep();
    t_fill_slc();
    t_fill_mlc();
    t_timing();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule